// File: doc/BRIEF.md
# E1 Frame and Multiframe Aligner

This block frames and deframes a 2.048 Mbit/s E1 stream bit by bit. One frame holds 32 eight-bit timeslots, numbered 0 to 31, and lasts 125 µs. Sixteen frames make one multiframe. A single bit-clock enable paces both directions. Each enable moves one line bit out of the transmitter and one line bit into the receiver.

The transmit half counts bit, timeslot and frame positions. It inserts the overhead words into timeslot 0 and into timeslot 16 of frame 0. Every other position carries the caller's payload bit. The receive half hunts the serial input for the frame alignment word and confirms it over three frames. It then reports the frame number, the timeslot index, a strobe with each completed octet, and the two alarm bits received from the far end. Multiframe alignment is found separately, from the zero nibble in timeslot 16.

Top module: `e1_framer`

## Requirements
- R1: After reset, tx_bit, tx_ts and tx_frame are 0. The k-th enable (k counted from 0) puts out the bit at frame position k. After that edge, tx_ts equals (k/8) mod 32 and tx_frame equals (k/256) mod 16. While bit_en is low, all three outputs hold.
- R2: In frames with an even number, timeslot 0 is sent first bit first as 1,0,0,1,1,0,1,1. This is a fixed leading bit followed by the alignment word 0011011.
- R3: In frames with an odd number, timeslot 0 is sent as 1,1,tx_rai,1,1,1,1,1.
- R4: In frame 0, timeslot 16 is sent as 0,0,0,0,1,tx_mfa,1,1. Every other position, including timeslot 16 of frames 1 to 15, carries tx_payload.
- R5: After reset, rx_frame_lock is 0. Lock is set on the edge that takes the last bit of the third timeslot 0 in this sequence: the word 0011011 in bits 1 to 7, then a 1 in bit 1 one frame later, then 0011011 again one frame after that. rx_frame is set to 0 on the frame where the word was first found. It counts frames from there.
- R6: If the middle frame of that sequence has a 0 in bit 1 of timeslot 0, the receiver goes back to a bit-by-bit hunt.
- R7: While locked, the receiver checks the alignment word in each even frame. It drops lock on the third errored word in a row. One or two errored words followed by a good one keep lock. After a loss, the hunt restarts at once.
- R8: While locked, each received timeslot ends with a one-cycle rx_ts_strobe. At the same time, rx_octet shows that timeslot's eight bits, first bit in bit 7, and rx_ts gives its index.
- R9: While locked, rx_rai takes bit 2 of timeslot 0 of each odd frame.
- R10: Timeslot 16 of an even frame whose upper nibble is 0000 sets rx_frame to 0. If the same pattern is seen again 16 frames later, rx_mf_lock is set and rx_mfa takes bit 5 of that octet.
- R11: rx_mf_lock clears when frame lock is lost. It is never 1 while rx_frame_lock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One line bit per cycle where high, both directions |
| tx_payload | input | 1 | Payload bit for non-overhead transmit positions |
| tx_rai | input | 1 | Remote alarm bit to send in odd frames |
| tx_mfa | input | 1 | Multiframe alarm bit to send in frame 0, timeslot 16 |
| tx_bit | output | 1 | Transmitted line bit |
| tx_ts | output | 5 | Timeslot of the bit on tx_bit |
| tx_frame | output | 4 | Frame number of the bit on tx_bit |
| rx_bit | input | 1 | Received line bit |
| rx_frame_lock | output | 1 | Frame alignment held |
| rx_mf_lock | output | 1 | Multiframe alignment held |
| rx_frame | output | 4 | Received frame number |
| rx_ts | output | 5 | Timeslot index of the receive position |
| rx_ts_strobe | output | 1 | One-cycle pulse at the end of each received timeslot |
| rx_octet | output | 8 | Last completed received timeslot |
| rx_rai | output | 1 | Received remote alarm bit |
| rx_mfa | output | 1 | Received multiframe alarm bit |

## Verification
Every result is due on the clock edge that accepts the enable carrying the deciding bit. The bench drives one bit per step, waits for that edge, and samples at the falling edge that follows. There is no added latency in either direction. The transmit bit for position k is compared right after enable k. Lock, loss, alarm and multiframe results are compared at the exact stream positions the requirements name, and also one bit earlier where the earlier value matters. Random idle cycles between enables confirm that outputs hold and that the strobe stays low.

// File: rtl/e1_pkg.sv
package e1_pkg;
  localparam int OCTET_BITS = 8;
  localparam int BIT_IDX_W  = 3;
  localparam logic [6:0] FAS_PATTERN = 7'b0011011;

  typedef enum logic [1:0] {AL_HUNT, AL_NFAS, AL_FAS2, AL_SYNC} align_state_t;
  typedef enum logic [1:0] {MF_HUNT, MF_CHECK, MF_SYNC} mf_state_t;
endpackage

// File: rtl/e1_tx_gen.sv
module e1_tx_gen import e1_pkg::*; #(
  parameter int TS_PER_FRAME  = 32,
  parameter int FRAMES_PER_MF = 16,
  parameter int MF_TS         = 16,
  localparam int TW = $clog2(TS_PER_FRAME),
  localparam int FW = $clog2(FRAMES_PER_MF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          tx_payload,
  input  logic          tx_rai,
  input  logic          tx_mfa,
  output logic          tx_bit,
  output logic [TW-1:0] tx_ts,
  output logic [FW-1:0] tx_frame
);
  localparam logic [OCTET_BITS-1:0] EVEN_WORD = {1'b1, FAS_PATTERN};

  logic [BIT_IDX_W-1:0] bit_q;
  logic [TW-1:0]        ts_q;
  logic [FW-1:0]        frm_q;
  logic [OCTET_BITS-1:0] odd_word, mf_word;
  logic nb, ts_last, frm_last;

  always_comb begin
    odd_word = {2'b11, tx_rai, 5'b11111};
    mf_word  = {4'b0000, 1'b1, tx_mfa, 2'b11};
    ts_last  = (ts_q == TW'(TS_PER_FRAME - 1));
    frm_last = (frm_q == FW'(FRAMES_PER_MF - 1));
    nb = tx_payload;
    if (ts_q == '0)
      nb = frm_q[0] ? odd_word[~bit_q] : EVEN_WORD[~bit_q];
    else if (ts_q == TW'(MF_TS) && frm_q == '0)
      nb = mf_word[~bit_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q    <= '0;
      ts_q     <= '0;
      frm_q    <= '0;
      tx_bit   <= 1'b0;
      tx_ts    <= '0;
      tx_frame <= '0;
    end else if (bit_en) begin
      tx_bit   <= nb;
      tx_ts    <= ts_q;
      tx_frame <= frm_q;
      bit_q    <= bit_q + 1'b1;
      if (bit_q == BIT_IDX_W'(OCTET_BITS - 1)) begin
        ts_q <= ts_last ? '0 : ts_q + 1'b1;
        if (ts_last) frm_q <= frm_last ? '0 : frm_q + 1'b1;
      end
    end
  end

  p_tx_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit) && $stable(tx_ts) && $stable(tx_frame));

  p_tx_nfas_one_r3: assert property (@(posedge clk) disable iff (rst)
    bit_en && ts_q == '0 && frm_q[0] && bit_q == 3'd1 |=> tx_bit);

  p_tx_mf_zero_r4: assert property (@(posedge clk) disable iff (rst)
    bit_en && ts_q == TW'(MF_TS) && frm_q == '0 && !bit_q[2] |=> !tx_bit);
endmodule

// File: rtl/e1_rx_align.sv
module e1_rx_align import e1_pkg::*; #(
  parameter int TS_PER_FRAME  = 32,
  parameter int MF_TS         = 16,
  parameter int FAS_ERR_LIMIT = 3,
  localparam int TW = $clog2(TS_PER_FRAME),
  localparam int PW = TW + BIT_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  rx_bit,
  input  logic                  frm_lsb,
  output logic                  lock,
  output logic [OCTET_BITS-1:0] sh_new,
  output logic                  ev_found,
  output logic                  ev_wrap,
  output logic                  ev_lost,
  output logic                  ev_ts16,
  output logic [TW-1:0]         rx_ts,
  output logic                  rx_ts_strobe,
  output logic [OCTET_BITS-1:0] rx_octet,
  output logic                  rx_rai
);
  localparam int FRAME_BITS = TS_PER_FRAME * OCTET_BITS;
  localparam int LAST_BIT   = OCTET_BITS - 1;
  localparam int TS16_END   = MF_TS * OCTET_BITS + LAST_BIT;
  localparam int EW         = $clog2(FAS_ERR_LIMIT + 1);

  align_state_t          st_q;
  logic [PW-1:0]         pos_q, pos_inc;
  logic [OCTET_BITS-1:0] sh_q;
  logic [EW-1:0]         err_q;
  logic fas_ok, ts0_end, fas_chk;

  always_comb begin
    sh_new   = {sh_q[OCTET_BITS-2:0], rx_bit};
    pos_inc  = (pos_q == PW'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
    fas_ok   = (sh_new[6:0] == FAS_PATTERN);
    ts0_end  = (pos_inc == PW'(LAST_BIT));
    ev_found = bit_en && st_q == AL_HUNT && fas_ok;
    ev_wrap  = bit_en && !ev_found && pos_inc == '0;
    ev_ts16  = bit_en && st_q == AL_SYNC && pos_inc == PW'(TS16_END);
    fas_chk  = bit_en && st_q == AL_SYNC && ts0_end && !frm_lsb;
    ev_lost  = fas_chk && !fas_ok && err_q == EW'(FAS_ERR_LIMIT - 1);
  end

  assign lock  = (st_q == AL_SYNC);
  assign rx_ts = pos_q[PW-1:BIT_IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= AL_HUNT;
      pos_q        <= '1;
      sh_q         <= '0;
      err_q        <= '0;
      rx_ts_strobe <= 1'b0;
      rx_octet     <= '0;
      rx_rai       <= 1'b0;
    end else begin
      rx_ts_strobe <= 1'b0;
      if (bit_en) begin
        sh_q  <= sh_new;
        pos_q <= ev_found ? PW'(LAST_BIT) : pos_inc;
        if (st_q == AL_SYNC && pos_inc[BIT_IDX_W-1:0] == BIT_IDX_W'(LAST_BIT)) begin
          rx_ts_strobe <= 1'b1;
          rx_octet     <= sh_new;
        end
        case (st_q)
          AL_HUNT: if (fas_ok) st_q <= AL_NFAS;
          AL_NFAS: if (ts0_end) st_q <= sh_new[6] ? AL_FAS2 : AL_HUNT;
          AL_FAS2: if (ts0_end) begin
            st_q  <= fas_ok ? AL_SYNC : AL_HUNT;
            err_q <= '0;
          end
          default: if (ts0_end) begin
            if (!frm_lsb) begin
              if (fas_ok) err_q <= '0;
              else if (ev_lost) begin
                st_q  <= AL_HUNT;
                err_q <= '0;
              end else err_q <= err_q + 1'b1;
            end else begin
              rx_rai <= sh_new[5];
            end
          end
        endcase
      end
    end
  end

  p_lock_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(st_q) == AL_FAS2);

  p_loss_count_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) && !$past(rst) |-> $past(err_q) == EW'(FAS_ERR_LIMIT - 1));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    rx_ts_strobe |=> !rx_ts_strobe);
endmodule

// File: rtl/e1_rx_mf.sv
module e1_rx_mf import e1_pkg::*; #(
  parameter int FRAMES_PER_MF = 16,
  localparam int FW = $clog2(FRAMES_PER_MF)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ev_found,
  input  logic                  ev_wrap,
  input  logic                  ev_lost,
  input  logic                  ev_ts16,
  input  logic [OCTET_BITS-1:0] octet,
  output logic [FW-1:0]         frame,
  output logic                  mf_lock,
  output logic                  mfa
);
  mf_state_t st_q;
  logic nib_zero, at_f0;

  assign nib_zero = (octet[7:4] == 4'b0000);
  assign at_f0    = (frame == '0);
  assign mf_lock  = (st_q == MF_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= '0;
      st_q  <= MF_HUNT;
      mfa   <= 1'b0;
    end else begin
      if (ev_found) frame <= '0;
      else if (ev_wrap)
        frame <= (frame == FW'(FRAMES_PER_MF - 1)) ? '0 : frame + 1'b1;
      if (ev_lost) st_q <= MF_HUNT;
      else if (ev_ts16) begin
        case (st_q)
          MF_HUNT: if (!frame[0] && nib_zero) begin
            frame <= '0;
            st_q  <= MF_CHECK;
          end
          MF_CHECK: if (at_f0) begin
            if (nib_zero) begin
              st_q <= MF_SYNC;
              mfa  <= octet[2];
            end else st_q <= MF_HUNT;
          end
          default: if (at_f0) mfa <= octet[2];
        endcase
      end
    end
  end

  p_mf_entry_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_lock) |-> frame == '0);
endmodule

// File: rtl/e1_framer.sv
module e1_framer import e1_pkg::*; #(
  parameter int TS_PER_FRAME  = 32,
  parameter int FRAMES_PER_MF = 16,
  parameter int MF_TS         = 16,
  parameter int FAS_ERR_LIMIT = 3,
  localparam int TW = $clog2(TS_PER_FRAME),
  localparam int FW = $clog2(FRAMES_PER_MF)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  tx_payload,
  input  logic                  tx_rai,
  input  logic                  tx_mfa,
  output logic                  tx_bit,
  output logic [TW-1:0]         tx_ts,
  output logic [FW-1:0]         tx_frame,
  input  logic                  rx_bit,
  output logic                  rx_frame_lock,
  output logic                  rx_mf_lock,
  output logic [FW-1:0]         rx_frame,
  output logic [TW-1:0]         rx_ts,
  output logic                  rx_ts_strobe,
  output logic [OCTET_BITS-1:0] rx_octet,
  output logic                  rx_rai,
  output logic                  rx_mfa
);
  logic [OCTET_BITS-1:0] sh_new;
  logic ev_found, ev_wrap, ev_lost, ev_ts16;

  e1_tx_gen #(.TS_PER_FRAME(TS_PER_FRAME), .FRAMES_PER_MF(FRAMES_PER_MF), .MF_TS(MF_TS)) tx_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_payload(tx_payload),
    .tx_rai(tx_rai), .tx_mfa(tx_mfa), .tx_bit(tx_bit), .tx_ts(tx_ts), .tx_frame(tx_frame));

  e1_rx_align #(.TS_PER_FRAME(TS_PER_FRAME), .MF_TS(MF_TS), .FAS_ERR_LIMIT(FAS_ERR_LIMIT)) al_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .frm_lsb(rx_frame[0]),
    .lock(rx_frame_lock), .sh_new(sh_new), .ev_found(ev_found), .ev_wrap(ev_wrap),
    .ev_lost(ev_lost), .ev_ts16(ev_ts16), .rx_ts(rx_ts), .rx_ts_strobe(rx_ts_strobe),
    .rx_octet(rx_octet), .rx_rai(rx_rai));

  e1_rx_mf #(.FRAMES_PER_MF(FRAMES_PER_MF)) mf_i (
    .clk(clk), .rst(rst), .ev_found(ev_found), .ev_wrap(ev_wrap), .ev_lost(ev_lost),
    .ev_ts16(ev_ts16), .octet(sh_new), .frame(rx_frame), .mf_lock(rx_mf_lock), .mfa(rx_mfa));

  p_mf_follows_frame_r11: assert property (@(posedge clk) disable iff (rst)
    rx_mf_lock |-> rx_frame_lock);
endmodule

// File: tb/e1_framer_tb_top.sv
module e1_framer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0;
  logic tx_payload = 1'b0, tx_rai = 1'b0, tx_mfa = 1'b0, rx_bit = 1'b0;
  logic tx_bit, rx_frame_lock, rx_mf_lock, rx_ts_strobe, rx_rai, rx_mfa;
  logic [4:0] tx_ts, rx_ts;
  logic [3:0] tx_frame, rx_frame;
  logic [7:0] rx_octet;

  e1_framer dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_payload(tx_payload), .tx_rai(tx_rai),
    .tx_mfa(tx_mfa), .tx_bit(tx_bit), .tx_ts(tx_ts), .tx_frame(tx_frame), .rx_bit(rx_bit),
    .rx_frame_lock(rx_frame_lock), .rx_mf_lock(rx_mf_lock), .rx_frame(rx_frame),
    .rx_ts(rx_ts), .rx_ts_strobe(rx_ts_strobe), .rx_octet(rx_octet),
    .rx_rai(rx_rai), .rx_mfa(rx_mfa));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int tx_k = 0, rx_q = 0, corrupt_left = 0;
  bit rai_s = 1'b1, mfa_s = 1'b1, rx_rand = 1'b0, break_nfas = 1'b0;
  logic [7:0] sh_m = '0;

  function automatic bit e1_bit(int p, bit rai, bit mfa, bit pay);
    int fr = (p / 256) % 16;
    int ts = (p / 8) % 32;
    int b  = p % 8;
    logic [7:0] w;
    if (ts == 0) w = (fr % 2 == 0) ? 8'b1001_1011 : {2'b11, rai, 5'b11111};
    else if (ts == 16 && fr == 0) w = {4'b0000, 1'b1, mfa, 2'b11};
    else return pay;
    return w[7 - b];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    bit exp_tx, rb, lock_prev;
    int b, ts, fr, tts, tfr;
    logic prev_bit;
    logic [4:0] prev_ts;
    if ($urandom % 8 == 0) begin
      prev_bit = tx_bit; prev_ts = tx_ts;
      bit_en = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(tx_bit == prev_bit && tx_ts == prev_ts, "R1 hold", tx_bit, prev_bit);
      chk(rx_ts_strobe == 1'b0, "R8 idle strobe", rx_ts_strobe, 0);
    end
    tx_payload = 1'($urandom);
    if (tx_k % 256 == 0) begin tx_rai = 1'($urandom); tx_mfa = 1'($urandom); end
    exp_tx = e1_bit(tx_k, tx_rai, tx_mfa, tx_payload);
    b = rx_q % 8; ts = (rx_q / 8) % 32; fr = (rx_q / 256) % 16;
    rb = e1_bit(rx_q, rai_s, mfa_s, rx_rand ? 1'($urandom) : 1'b1);
    if (ts == 0 && fr % 2 == 0 && b == 1 && corrupt_left > 0) begin rb = ~rb; corrupt_left--; end
    if (ts == 0 && fr % 2 == 1 && b == 1 && break_nfas) begin rb = 1'b0; break_nfas = 1'b0; end
    rx_bit = rb; bit_en = 1'b1; lock_prev = rx_frame_lock;
    @(posedge clk); @(negedge clk);
    bit_en = 1'b0;
    sh_m = {sh_m[6:0], rb};
    tts = (tx_k / 8) % 32; tfr = (tx_k / 256) % 16;
    if (tts == 0) chk(tx_bit == exp_tx, (tfr % 2 == 0) ? "R2 even ts0" : "R3 odd ts0", tx_bit, exp_tx);
    else chk(tx_bit == exp_tx, "R4 ts16/payload", tx_bit, exp_tx);
    chk(tx_ts == 5'(tts) && tx_frame == 4'(tfr), "R1 position", {tx_frame, tx_ts}, tfr * 32 + tts);
    if (lock_prev) begin
      chk(rx_ts_strobe == (b == 7), "R8 strobe", rx_ts_strobe, b == 7);
      chk(rx_ts == 5'(ts), "R8 ts index", rx_ts, ts);
      if (b == 7) chk(rx_octet == sh_m, "R8 octet", rx_octet, sh_m);
    end
    tx_k++; rx_q++;
  endtask

  task automatic run_to(int last);
    while (rx_q <= last) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; tx_k = 0; rx_q = 0; sh_m = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", rx_q, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    chk(tx_bit == 0 && tx_ts == 0 && tx_frame == 0, "R1 reset tx", tx_bit, 0);
    chk(rx_frame_lock == 0 && rx_mf_lock == 0 && rx_ts_strobe == 0, "R5 reset rx", rx_frame_lock, 0);
    chk(rx_frame == 0, "R5 reset frame", rx_frame, 0);
    // R5: three-frame confirmation
    run_to(7);          chk(rx_frame_lock == 0, "R5 first fas only", rx_frame_lock, 0);
    run_to(512 + 6);    chk(rx_frame_lock == 0, "R5 before third ts0", rx_frame_lock, 0);
    run_to(512 + 7);    chk(rx_frame_lock == 1, "R5 lock", rx_frame_lock, 1);
    chk(rx_frame == 2, "R5 frame count", rx_frame, 2);
    run_to(768 + 7);    chk(rx_rai == 1, "R9 rai set", rx_rai, 1);
    // R10: multiframe
    run_to(16*256 + 135); chk(rx_mf_lock == 0, "R10 first mfas", rx_mf_lock, 0);
    chk(rx_frame == 0, "R10 frame zero", rx_frame, 0);
    run_to(32*256 + 134); chk(rx_mf_lock == 0, "R10 before second", rx_mf_lock, 0);
    run_to(32*256 + 135); chk(rx_mf_lock == 1, "R10 mf lock", rx_mf_lock, 1);
    chk(rx_mfa == 1, "R10 mfa", rx_mfa, 1);
    run_to(33*256 + 10);  chk(rx_frame == 1, "R10 frame follows", rx_frame, 1);
    // R7: two errors tolerated
    corrupt_left = 2;
    run_to(38*256 + 7);   chk(rx_frame_lock == 1, "R7 two errors kept", rx_frame_lock, 1);
    // R7/R11: three errors drop lock
    corrupt_left = 3;
    run_to(44*256 + 6);   chk(rx_frame_lock == 1, "R7 before third error", rx_frame_lock, 1);
    run_to(44*256 + 7);   chk(rx_frame_lock == 0, "R7 loss", rx_frame_lock, 0);
    chk(rx_mf_lock == 0, "R11 mf drop", rx_mf_lock, 0);
    run_to(48*256 + 6);   chk(rx_frame_lock == 0, "R7 rehunt pending", rx_frame_lock, 0);
    run_to(48*256 + 7);   chk(rx_frame_lock == 1, "R7 relock", rx_frame_lock, 1);
    // R9: alarm clears
    rai_s = 1'b0;
    run_to(49*256 + 7);   chk(rx_rai == 0, "R9 rai clear", rx_rai, 0);
    // R8: random payload pass-through
    rx_rand = 1'b1;
    run_to(52*256 + 7);   chk(rx_frame_lock == 1, "R8 lock kept random", rx_frame_lock, 1);
    // R6: broken NFAS forces a new hunt
    do_reset();
    rx_rand = 1'b0; rai_s = 1'b1; break_nfas = 1'b1;
    run_to(512 + 7);      chk(rx_frame_lock == 0, "R6 no lock after bad nfas", rx_frame_lock, 0);
    run_to(1024 + 6);     chk(rx_frame_lock == 0, "R6 before relock", rx_frame_lock, 0);
    run_to(1024 + 7);     chk(rx_frame_lock == 1, "R6 relock", rx_frame_lock, 1);
    summary();
    $finish;
  end
endmodule